// File: doc/BRIEF.md
# Multi-Mode Down-Counting Timer

This block is a 16-bit down-counter shared by four operating modes. It can act as a pulse-width generator with separately programmed low and high times, or as a counter of edges on an external pin. It can also latch the running count when a selected pin edge occurs. In difference mode it latches the number of count steps that passed between two selected pin edges, so firmware does not have to subtract.

Firmware presents the control fields and reload values as static inputs. It starts and stops the block with a run bit and clears the two sticky flags with single-cycle clear strobes. The external pin may be asynchronous. It passes through a synchroniser before edge detection.

Top module: `mode_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears `count`, `pend`, `pwm_out`, `cap_val` and `cap_pend` to zero.
- R2: While `run_en` is 0, each clock loads `count` from `reload_a` and drives `pwm_out` to 0. No count step occurs and no flag is set.
- R3: With `mode` = 2'b00 (pulse mode) and `run_en` = 1, `count` drops by one on each clock where `tick_en` = 1. It holds on every other clock.
- R4: In pulse mode, a step taken from `count` = 0 is an underflow, and it toggles `pwm_out`. If `pwm_out` was 0, the counter reloads from `reload_b`; otherwise it reloads from `reload_a`. After a start, `pwm_out` is therefore low for `reload_a`+1 ticks and high for `reload_b`+1 ticks. `pwm_out` changes only on such underflows or on a stop.
- R5: Every underflow, in any mode, sets `pend`. `pend` stays set until a clock with `pend_clr` = 1 and no underflow. An underflow in the same clock as the clear wins.
- R6: With `mode` = 2'b01 (event mode), `count` drops by one on each selected edge of `ext_in` and ignores `tick_en`. `edge_sel` = 1 selects rising edges and 0 selects falling edges. In every mode other than pulse mode, an underflow reloads from `reload_a` and leaves `pwm_out` unchanged.
- R7: `ext_in` passes through two synchronising flops. A level change of `ext_in` that is present at clock edge k acts on the counter or capture logic at clock edge k+2.
- R8: With `mode` = 2'b10 (capture mode), the counter steps on `tick_en` as in R3. Each selected edge of `ext_in` copies the current `count` into `cap_val` and sets `cap_pend`.
- R9: With `mode` = 2'b11 (difference mode), the counter steps on `tick_en`. Each selected edge loads `cap_val` with (reference − `count`) mod 2^16 and sets `cap_pend`. The reference is `count` at the previous selected edge, or `reload_a` if no edge has occurred since the block was started.
- R10: `cap_pend` stays set until a clock with `cap_clr` = 1 and no capture. A capture in the same clock as the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Start (1) or stop and preset (0) |
| tick_en | input | 1 | Instruction-clock enable |
| mode | input | 2 | 00 pulse, 01 event, 10 capture, 11 difference |
| edge_sel | input | 1 | 1 rising, 0 falling edge of `ext_in` |
| ext_in | input | 1 | External pin, asynchronous |
| reload_a | input | 16 | Reload value A (low time, preset) |
| reload_b | input | 16 | Reload value B (high time) |
| pend_clr | input | 1 | Clear strobe for `pend` |
| cap_clr | input | 1 | Clear strobe for `cap_pend` |
| count | output | 16 | Current counter value |
| pend | output | 1 | Sticky underflow flag |
| pwm_out | output | 1 | Toggling pulse output |
| cap_val | output | 16 | Captured count or elapsed count |
| cap_pend | output | 1 | Sticky capture flag |

## Verification
A wrong step condition or a wrong reload choice appears on `count` in the next clock. In pulse mode it also appears on `pwm_out` at the following underflow. A fault in the synchroniser depth moves each event-mode step and each capture one clock earlier or later, and `count` or `cap_val` shows this within three clocks of the pin change. A stale difference reference affects only the next capture, where `cap_val` comes out wrong by the offset. The bench therefore compares every port against a requirement model on every clock. It also times the pulse phases and the pin latency directly.

// File: rtl/mt_pkg.sv
// Package: shared types for the multi-mode timer.
package mt_pkg;
    typedef enum logic [1:0] {
        MODE_PULSE = 2'b00,
        MODE_EVENT = 2'b01,
        MODE_CAPT  = 2'b10,
        MODE_DIFF  = 2'b11
    } tmr_mode_e;
endpackage

// File: rtl/mt_edge_sync.sv
// Synchroniser and edge detector for the external pin.
// Assumes async_in may change at any time; STAGES >= 2 flops precede the
// edge compare, so a change acts on dependent logic STAGES clocks later.
module mt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    input  logic rise_sel,
    output logic sel_edge
);
    logic [STAGES-1:0] chain;
    logic              last;
    logic              rise;
    logic              fall;

    // Shift the pin through the synchroniser and keep the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
            last  <= chain[STAGES-1];
        end
    end

    // Edge decode on the synchronised level.
    always_comb begin
        rise     = chain[STAGES-1] & ~last;
        fall     = ~chain[STAGES-1] & last;
        sel_edge = rise_sel ? rise : fall;
    end

    // R7: a detected rising edge comes from the previous synchroniser stage.
    a_r7_rise_from_chain: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> $past(chain[STAGES-2]));
endmodule

// File: rtl/mt_counter.sv
// Down-counter with alternating reload, pulse output and underflow flag.
// Assumes the control inputs are stable and the edge pulse is synchronous.
module mt_counter
    import mt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic         tick_en,
    input  tmr_mode_e    mode,
    input  logic         evt_edge,
    input  logic [W-1:0] reload_a,
    input  logic [W-1:0] reload_b,
    input  logic         pend_clr,
    output logic [W-1:0] count,
    output logic         pend,
    output logic         pwm_out
);
    logic         dec;
    logic         uflow;
    logic         pulse_mode;
    logic [W-1:0] reload_val;

    // Step condition, underflow detect and reload choice.
    always_comb begin
        pulse_mode = (mode == MODE_PULSE);
        dec        = run_en && ((mode == MODE_EVENT) ? evt_edge : tick_en);
        uflow      = dec && (count == '0);
        reload_val = (pulse_mode && !pwm_out) ? reload_b : reload_a;
    end

    // Counter and pulse output update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            pwm_out <= 1'b0;
        end else if (!run_en) begin
            count   <= reload_a;
            pwm_out <= 1'b0;
        end else if (uflow) begin
            count <= reload_val;
            if (pulse_mode) pwm_out <= ~pwm_out;
        end else if (dec) begin
            count <= count - 1'b1;
        end
    end

    // Sticky underflow flag; a new underflow beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend <= 1'b0;
        else if (uflow)    pend <= 1'b1;
        else if (pend_clr) pend <= 1'b0;
    end

    // R3: without a step the count holds while running.
    a_r3_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !dec) |=> (count == $past(count)));
    // R3: a step from a nonzero value lowers the count by one.
    a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && count != '0) |=> (count == $past(count) - 1'b1));
    // R4: the pulse output only moves on underflow or stop.
    a_r4_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !uflow) |=> $stable(pwm_out));
    // R5: the underflow flag is sticky until cleared.
    a_r5_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !pend_clr) |=> pend);
    // R6: non-pulse underflow reloads from A.
    a_r6_reload_a: assert property (@(posedge clk) disable iff (!rst_n)
        (uflow && !pulse_mode) |=> (count == $past(reload_a)));
endmodule

// File: rtl/mt_capture.sv
// Capture register for plain and difference capture modes.
// Assumes cap_edge is a one-clock synchronous pulse; the difference
// reference is re-seeded from reload_a while the block is stopped.
module mt_capture
    import mt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  tmr_mode_e    mode,
    input  logic         cap_edge,
    input  logic [W-1:0] count,
    input  logic [W-1:0] reload_a,
    input  logic         cap_clr,
    output logic [W-1:0] cap_val,
    output logic         cap_pend
);
    logic         cap_en;
    logic         diff_mode;
    logic [W-1:0] ref_cnt;
    logic [W-1:0] next_cap;

    // Capture enable and captured value.
    always_comb begin
        diff_mode = (mode == MODE_DIFF);
        cap_en    = run_en && cap_edge && (mode == MODE_CAPT || diff_mode);
        next_cap  = diff_mode ? (ref_cnt - count) : count;
    end

    // Difference reference tracks the count at each capture.
    always_ff @(posedge clk) begin
        if (!rst_n)                   ref_cnt <= '0;
        else if (!run_en)             ref_cnt <= reload_a;
        else if (cap_en && diff_mode) ref_cnt <= count;
    end

    // Capture register and sticky capture flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_val  <= '0;
            cap_pend <= 1'b0;
        end else if (cap_en) begin
            cap_val  <= next_cap;
            cap_pend <= 1'b1;
        end else if (cap_clr) begin
            cap_pend <= 1'b0;
        end
    end

    // R8: plain capture records the running count.
    a_r8_capture_count: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && !diff_mode) |=> (cap_val == $past(count)));
    // R10: the capture flag is sticky until cleared.
    a_r10_cap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_pend && !cap_clr) |=> cap_pend);
    // R10: the captured value holds between captures.
    a_r10_cap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(cap_val));
endmodule

// File: rtl/mode_timer.sv
// Top: multi-mode down-counting timer (pulse, event, capture, difference).
// Assumes control fields are quasi-static and ext_in may be asynchronous.
module mode_timer
    import mt_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic         tick_en,
    input  logic [1:0]   mode,
    input  logic         edge_sel,
    input  logic         ext_in,
    input  logic [W-1:0] reload_a,
    input  logic [W-1:0] reload_b,
    input  logic         pend_clr,
    input  logic         cap_clr,
    output logic [W-1:0] count,
    output logic         pend,
    output logic         pwm_out,
    output logic [W-1:0] cap_val,
    output logic         cap_pend
);
    tmr_mode_e mode_q;
    logic      pin_edge;

    // Map the raw mode field onto the shared type.
    always_comb mode_q = tmr_mode_e'(mode);

    mt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_in),
        .rise_sel (edge_sel),
        .sel_edge (pin_edge)
    );

    mt_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .tick_en  (tick_en),
        .mode     (mode_q),
        .evt_edge (pin_edge),
        .reload_a (reload_a),
        .reload_b (reload_b),
        .pend_clr (pend_clr),
        .count    (count),
        .pend     (pend),
        .pwm_out  (pwm_out)
    );

    mt_capture #(.W(W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .mode     (mode_q),
        .cap_edge (pin_edge),
        .count    (count),
        .reload_a (reload_a),
        .cap_clr  (cap_clr),
        .cap_val  (cap_val),
        .cap_pend (cap_pend)
    );

    // R2: a stopped timer presets from A with the output low.
    a_r2_stop_preset: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (count == $past(reload_a) && !pwm_out));
endmodule

// File: tb/mode_timer_tb.sv
// Self-checking bench: per-clock requirement model plus directed corners.
module mode_timer_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 0, tick_en = 0, edge_sel = 0, ext_in = 0;
    logic        pend_clr = 0, cap_clr = 0;
    logic [1:0]  mode = 2'b00;
    logic [15:0] reload_a = 0, reload_b = 0;
    logic [15:0] count, cap_val;
    logic        pend, pwm_out, cap_pend;

    int checks = 0;
    int fails  = 0;

    // Model state, built from the requirements.
    logic [15:0] m_cnt = 0, m_cap = 0, m_ref = 0;
    logic        m_pend = 0, m_out = 0, m_cpend = 0;
    logic        m_s1 = 0, m_s2 = 0, m_s3 = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mode_timer u_dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick_en(tick_en),
        .mode(mode), .edge_sel(edge_sel), .ext_in(ext_in),
        .reload_a(reload_a), .reload_b(reload_b), .pend_clr(pend_clr),
        .cap_clr(cap_clr), .count(count), .pend(pend), .pwm_out(pwm_out),
        .cap_val(cap_val), .cap_pend(cap_pend)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string mode_tag(input logic [1:0] md);
        case (md)
            2'b00: return "R4";
            2'b01: return "R6";
            2'b10: return "R8";
            default: return "R9";
        endcase
    endfunction

    // Advance the model by one clock using the current inputs (R1..R10).
    task automatic model_step();
        logic rise, fall, edg, dec, uf, capen;
        logic [15:0] n_cnt, n_cap, n_ref;
        logic n_out, n_pend, n_cpend;
        if (!rst_n) begin
            m_cnt = 0; m_cap = 0; m_ref = 0; m_pend = 0; m_out = 0; m_cpend = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
            return;
        end
        rise  = m_s2 & ~m_s3;
        fall  = ~m_s2 & m_s3;
        edg   = edge_sel ? rise : fall;
        dec   = run_en && ((mode == 2'b01) ? edg : tick_en);
        uf    = dec && (m_cnt == 0);
        capen = run_en && mode[1] && edg;
        n_cnt = m_cnt; n_out = m_out; n_ref = m_ref; n_cap = m_cap;
        if (!run_en) begin n_cnt = reload_a; n_out = 0; end
        else if (uf) begin
            n_cnt = (mode == 2'b00 && !m_out) ? reload_b : reload_a;
            if (mode == 2'b00) n_out = ~m_out;
        end else if (dec) n_cnt = m_cnt - 1;
        n_pend  = uf ? 1'b1 : (pend_clr ? 1'b0 : m_pend);
        n_cpend = capen ? 1'b1 : (cap_clr ? 1'b0 : m_cpend);
        if (!run_en) n_ref = reload_a;
        else if (capen && mode == 2'b11) n_ref = m_cnt;
        if (capen) n_cap = (mode == 2'b11) ? (m_ref - m_cnt) : m_cnt;
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_in;
        m_cnt = n_cnt; m_out = n_out; m_ref = n_ref; m_cap = n_cap;
        m_pend = n_pend; m_cpend = n_cpend;
    endtask

    // One clock: model update, edge, then compare away from the edge.
    task automatic step();
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk({count, pend, pwm_out, cap_val, cap_pend} == {m_cnt, m_pend, m_out, m_cap, m_cpend},
            mode_tag(mode),
            {29'd0, count, pend, pwm_out, cap_val, cap_pend},
            {29'd0, m_cnt, m_pend, m_out, m_cap, m_cpend});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd4711));
        @(negedge clk);
        repeat (3) step();
        // R1: reset state
        chk(count == 0 && !pend && !pwm_out && cap_val == 0 && !cap_pend, "R1",
            {count, pend, pwm_out, cap_val, cap_pend}, 0);
        rst_n = 1;

        // R2: stopped timer presets from A
        reload_a = 16'd5; run_en = 0; tick_en = 1; step();
        chk(count == 5 && !pwm_out && !pend, "R2", count, 5);

        // R3/R4: pulse phase lengths, A=2 gives 3 low ticks, B=4 gives 5 high ticks
        mode = 2'b00; reload_a = 2; reload_b = 4; run_en = 0; step();
        run_en = 1; tick_en = 1;
        n = 0; do begin step(); n++; end while (!pwm_out && n < 20);
        chk(n == 3, "R4 low", n, 3);
        n = 0; do begin step(); n++; end while (pwm_out && n < 20);
        chk(n == 5, "R4 high", n, 5);
        tick_en = 0; begin logic [15:0] c0; c0 = count; step(); chk(count == c0, "R3 hold", count, c0); end

        // R5: underflow beats clear, then clear works
        reload_a = 0; reload_b = 0; run_en = 0; step();
        run_en = 1; tick_en = 1; pend_clr = 1; step(); step();
        chk(pend == 1, "R5 set wins", pend, 1);
        tick_en = 0; step();
        chk(pend == 0, "R5 clear", pend, 0);
        pend_clr = 0;

        // R6/R7: event mode, rising edge, latency of two clocks, tick ignored
        mode = 2'b01; edge_sel = 1; reload_a = 9; run_en = 0; ext_in = 0;
        repeat (3) step();
        run_en = 1; tick_en = 1; step();
        chk(count == 9, "R6 tick ignored", count, 9);
        ext_in = 1; step();
        chk(count == 9, "R7 edge+1", count, 9);
        step();
        chk(count == 9, "R7 edge+2 pending", count, 9);
        step();
        chk(count == 8, "R7 acted", count, 8);
        ext_in = 0; repeat (3) step();
        chk(count == 8, "R6 falling ignored", count, 8);

        // R9: difference capture of 7 ticks between rising edges
        mode = 2'b11; edge_sel = 1; reload_a = 16'hFFFF; run_en = 0; ext_in = 0;
        repeat (3) step();
        run_en = 1; tick_en = 1; step();
        ext_in = 1; step(); step();
        ext_in = 0; repeat (5) step();
        ext_in = 1; repeat (4) step();
        chk(cap_val == 7 && cap_pend, "R9 elapsed", cap_val, 7);

        // R10: capture flag sticky, then cleared
        repeat (2) step();
        chk(cap_pend == 1, "R10 sticky", cap_pend, 1);
        cap_clr = 1; step(); cap_clr = 0;
        chk(cap_pend == 0, "R10 clear", cap_pend, 0);

        // Random phases per mode against the model (R3..R10)
        for (int md = 0; md < 4; md++) begin
            mode = md[1:0]; run_en = 0;
            reload_a = 16'($urandom_range(0, 7)); reload_b = 16'($urandom_range(0, 7));
            step();
            run_en = 1;
            for (int i = 0; i < 1500; i++) begin
                tick_en  = ($urandom_range(0, 1) == 1);
                if ($urandom_range(0, 2) == 0) ext_in = ~ext_in;
                pend_clr = ($urandom_range(0, 15) == 0);
                cap_clr  = ($urandom_range(0, 15) == 0);
                if ($urandom_range(0, 199) == 0) edge_sel = ~edge_sel;
                if ($urandom_range(0, 299) == 0) run_en = 0; else run_en = 1;
                step();
            end
        end
        pend_clr = 0; cap_clr = 0;

        // R8: directed plain capture of a known count
        mode = 2'b10; edge_sel = 0; reload_a = 16'd100; run_en = 0; ext_in = 1;
        repeat (3) step();
        run_en = 1; tick_en = 0; step();
        ext_in = 0; repeat (3) step();
        chk(cap_val == 100 && cap_pend, "R8 capture", cap_val, 100);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule